// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control state of a processor core behind a single indexed access port. Each request names a register index, says whether it reads or writes, and (for writes) carries 64 bits of data. Every index has its own rule. Some keep only certain bits of what is written. Some are zeroed by any write. One is forced to 1 by any write. Some are read-only or write-only. Some writes do nothing more than fire a flush command toward the instruction-side or data-side translation buffer. The response comes back one cycle after the request. It carries read data and a fault flag for accesses that break the index's access class.

A squash input marks the current request as speculative. A squashed write leaves every register unchanged, fires no flush, and raises no fault. The cycle-counter register combines its stored upper half with the low half of a free-running count supplied from outside. Reset puts every register into a known state, and one scratch register receives the processor ID.

Top module: `priv_ctl_regs`

## Requirements
- R1: While rst_n is low at a clock edge, every register is cleared to zero, with three exceptions: system control (index 0x09) takes 0x6, the privileged base register (0x08) takes the BASE_CONST parameter, and scratch register 0x07 takes the cpu_id input zero-extended to 64 bits.
- R2: A request accepted at a clock edge (req_valid high) produces rsp_valid, rsp_rdata and rsp_fault together at the next edge. When no request was accepted, rsp_valid is low. Write responses return zero data.
- R3: The following registers store and return all 64 bits: scratch 0x00 to 0x07, privileged base 0x08, and system control 0x09.
- R4: A write to the exception-address register (0x0A) stores the data with bit 1 forced to zero.
- R5: The trap-enable (0x0B) and trap-request (0x0C) registers keep only bits 3:0. The instruction-mode (0x0D) and data-mode (0x0E) registers keep only bits 4:3 (mask 0x18).
- R6: The cache-mode (0x0F) and miss-mode (0x10) registers keep bits 5:0. The instruction address-space register (0x11) keeps bits 10:4. The data address-space register (0x12) keeps bits 63:57. The two page-table base registers (0x13, 0x14) keep bits 63:30.
- R7: Any write to the exception-summary (0x15) or exception-mask (0x16) register sets it to zero, whatever the write data.
- R8: A write to the cycle-counter register (0x17) stores all 64 bits. A read returns the stored bits 63:32 above bits 31:0 of cyc_count as sampled at the request edge.
- R9: Any write to the cycle-control register (0x18) sets its stored value to 1. It is readable.
- R10: The following accesses raise rsp_fault, return zero data, and change no register and no flush output: a write to the read-only interrupt-ID register (0x19), a read of a write-only invalidate register (0x1A to 0x1F), and any access to an index at or above 0x20.
- R11: A write to invalidate-all (0x1A instruction, 0x1D data) or invalidate-per-process (0x1B instruction, 0x1E data) pulses the matching bit of flush_all or flush_proc high for exactly one cycle, aligned with the response. Bit 0 is the instruction side and bit 1 is the data side.
- R12: A write to invalidate-single (0x1C instruction, 0x1F data) pulses the matching bit of flush_one for one cycle, aligned with the response. In that cycle flush_addr equals the write data and flush_asn carries that side's current address-space number: bits 10:4 of 0x11 for the instruction side, bits 63:57 of 0x12 for the data side.
- R13: When squash is high with a write request, no register changes, no flush bit rises, and rsp_fault stays low. Reads under squash are served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Register index |
| req_wdata | input | 64 | Write data |
| squash | input | 1 | Marks the request speculative; suppresses writes |
| cyc_count | input | 64 | Free-running cycle count |
| cpu_id | input | ID_W | Processor ID loaded at reset |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_fault | output | 1 | Access-class fault |
| flush_all | output | 2 | Invalidate-all strobes (bit 0 instruction, bit 1 data) |
| flush_proc | output | 2 | Invalidate-per-process strobes |
| flush_one | output | 2 | Invalidate-single strobes |
| flush_addr | output | 64 | Address for the single-entry invalidate |
| flush_asn | output | 7 | Address-space number for the single-entry invalidate |

## Verification
The main function is exercised with writes of all ones followed by read-back. All ones exposes every bit a mask should drop, so a mask that is too wide or too narrow gives a different value. Mixed patterns separate the bit-1 clear from a plain mask and the mode-bit mask from the low-bit masks. Flush writes are issued on both sides with distinct address-space numbers loaded beforehand, so swapped sides or a stale number show up directly. The same writes are then repeated under squash and compared against the values already stored.

// File: rtl/priv_ctl_pkg.sv
// Shared definitions for the privileged control register file: index map,
// per-index write masks, access classes and the decoded-rule record.
// Assumes a 64-bit data path; indices fit in 5 bits.
package priv_ctl_pkg;

    localparam int DATA_W    = 64;
    localparam int ASN_W     = 7;
    localparam int SIDES     = 2;   // 0 = instruction side, 1 = data side
    localparam int SCRATCH_N = 8;
    localparam int REG_COUNT = 32;

    localparam int IX_BASE      = 8;
    localparam int IX_SYSCTL    = 9;
    localparam int IX_EXC_ADDR  = 10;
    localparam int IX_TRAP_EN   = 11;
    localparam int IX_TRAP_REQ  = 12;
    localparam int IX_MODE_I    = 13;
    localparam int IX_MODE_D    = 14;
    localparam int IX_CACHE_MD  = 15;
    localparam int IX_MISS_MD   = 16;
    localparam int IX_ASN_I     = 17;
    localparam int IX_ASN_D     = 18;
    localparam int IX_PTB_I     = 19;
    localparam int IX_PTB_D     = 20;
    localparam int IX_EXC_SUM   = 21;
    localparam int IX_EXC_MSK   = 22;
    localparam int IX_CYC       = 23;
    localparam int IX_CYC_CTL   = 24;
    localparam int IX_INT_ID    = 25;
    localparam int IX_INV_ALL_I = 26;
    localparam int IX_INV_PRC_I = 27;
    localparam int IX_INV_ONE_I = 28;
    localparam int IX_INV_ALL_D = 29;
    localparam int IX_INV_PRC_D = 30;
    localparam int IX_INV_ONE_D = 31;

    localparam logic [DATA_W-1:0] M_EXC_ADDR = ~64'h2;
    localparam logic [DATA_W-1:0] M_TRAP     = 64'hF;
    localparam logic [DATA_W-1:0] M_MODE     = 64'h18;
    localparam logic [DATA_W-1:0] M_CMODE    = 64'h3F;
    localparam logic [DATA_W-1:0] M_ASN_I    = 64'h7F0;
    localparam logic [DATA_W-1:0] M_ASN_D    = 64'hFE00_0000_0000_0000;
    localparam logic [DATA_W-1:0] M_PTB      = 64'hFFFF_FFFF_C000_0000;

    localparam int ASN_I_LSB = 4;
    localparam int ASN_D_LSB = 57;

    typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [DATA_W-1:0] wmask;
        logic              clr;       // any write stores zero
        logic              set1;      // any write stores one
        logic              cyc;       // read merges live count
        logic [SIDES-1:0]  inv_all;
        logic [SIDES-1:0]  inv_proc;
        logic [SIDES-1:0]  inv_one;
    } dec_t;

endpackage

// File: rtl/priv_ctl_decode.sv
// Index decoder: maps a register index to its access class, write mask and
// write side effect. Purely combinational; unknown indices get ACC_NONE.
module priv_ctl_decode
    import priv_ctl_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec
);

    // Rule lookup per index
    always_comb begin
        dec       = '0;
        dec.acc   = ACC_NONE;
        dec.wmask = '1;
        if (idx < IDX_W'(SCRATCH_N)) begin
            dec.acc = ACC_RW;
        end else begin
            case (idx)
                IDX_W'(IX_BASE), IDX_W'(IX_SYSCTL): dec.acc = ACC_RW;
                IDX_W'(IX_EXC_ADDR): begin dec.acc = ACC_RW; dec.wmask = M_EXC_ADDR; end
                IDX_W'(IX_TRAP_EN), IDX_W'(IX_TRAP_REQ):
                    begin dec.acc = ACC_RW; dec.wmask = M_TRAP; end
                IDX_W'(IX_MODE_I), IDX_W'(IX_MODE_D):
                    begin dec.acc = ACC_RW; dec.wmask = M_MODE; end
                IDX_W'(IX_CACHE_MD), IDX_W'(IX_MISS_MD):
                    begin dec.acc = ACC_RW; dec.wmask = M_CMODE; end
                IDX_W'(IX_ASN_I): begin dec.acc = ACC_RW; dec.wmask = M_ASN_I; end
                IDX_W'(IX_ASN_D): begin dec.acc = ACC_RW; dec.wmask = M_ASN_D; end
                IDX_W'(IX_PTB_I), IDX_W'(IX_PTB_D):
                    begin dec.acc = ACC_RW; dec.wmask = M_PTB; end
                IDX_W'(IX_EXC_SUM), IDX_W'(IX_EXC_MSK):
                    begin dec.acc = ACC_RW; dec.clr = 1'b1; end
                IDX_W'(IX_CYC):     begin dec.acc = ACC_RW; dec.cyc = 1'b1; end
                IDX_W'(IX_CYC_CTL): begin dec.acc = ACC_RW; dec.set1 = 1'b1; end
                IDX_W'(IX_INT_ID):  dec.acc = ACC_RO;
                IDX_W'(IX_INV_ALL_I): begin dec.acc = ACC_WO; dec.clr = 1'b1; dec.inv_all  = 2'b01; end
                IDX_W'(IX_INV_PRC_I): begin dec.acc = ACC_WO; dec.clr = 1'b1; dec.inv_proc = 2'b01; end
                IDX_W'(IX_INV_ONE_I): begin dec.acc = ACC_WO; dec.inv_one = 2'b01; end
                IDX_W'(IX_INV_ALL_D): begin dec.acc = ACC_WO; dec.clr = 1'b1; dec.inv_all  = 2'b10; end
                IDX_W'(IX_INV_PRC_D): begin dec.acc = ACC_WO; dec.clr = 1'b1; dec.inv_proc = 2'b10; end
                IDX_W'(IX_INV_ONE_D): begin dec.acc = ACC_WO; dec.inv_one = 2'b10; end
                default: dec.acc = ACC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/priv_ctl_strobe.sv
// Flush strobe register for one translation-buffer side. Turns accepted
// invalidate writes into one-cycle pulses aligned with the response.
// Assumes at most one invalidate kind fires per cycle.
module priv_ctl_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_all,
    input  logic hit_proc,
    input  logic hit_one,
    output logic pulse_all,
    output logic pulse_proc,
    output logic pulse_one
);

    // Register the invalidate hits into pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_all  <= 1'b0;
            pulse_proc <= 1'b0;
            pulse_one  <= 1'b0;
        end else begin
            pulse_all  <= hit_all;
            pulse_proc <= hit_proc;
            pulse_one  <= hit_one;
        end
    end

    assert_one_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pulse_all, pulse_proc, pulse_one}));

    assert_pulse_from_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_all |-> $past(hit_all));

endmodule

// File: rtl/priv_ctl_regs.sv
// Privileged control register file. One indexed access port with one cycle
// of response latency; per-index masking, clear/set side effects, access
// faults, cycle-count merge on read and translation-buffer flush strobes.
// Assumes one access per cycle and IDX_W >= 5.
module priv_ctl_regs
    import priv_ctl_pkg::*;
#(
    parameter int                IDX_W      = 6,
    parameter int                ID_W       = 8,
    parameter logic [DATA_W-1:0] BASE_CONST = 64'h0000_0000_0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              squash,
    input  logic [DATA_W-1:0] cyc_count,
    input  logic [ID_W-1:0]   cpu_id,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_fault,
    output logic [SIDES-1:0]  flush_all,
    output logic [SIDES-1:0]  flush_proc,
    output logic [SIDES-1:0]  flush_one,
    output logic [DATA_W-1:0] flush_addr,
    output logic [ASN_W-1:0]  flush_asn
);

    localparam int SEL_W  = $clog2(REG_COUNT);
    localparam int HALF_W = DATA_W / 2;

    dec_t              dec;
    logic [DATA_W-1:0] regs [REG_COUNT];
    logic [SEL_W-1:0]  sel;
    logic              readable, writable;
    logic              wr_ok, wr_bad, rd_bad;
    logic [DATA_W-1:0] wr_val, rd_val;
    logic [SIDES-1:0]  hit_all, hit_proc, hit_one;
    logic [ASN_W-1:0]  asn_i, asn_d;

    priv_ctl_decode #(.IDX_W(IDX_W)) u_dec (.idx(req_idx), .dec(dec));

    // Access-class checks and write gating
    always_comb begin
        sel      = req_idx[SEL_W-1:0];
        readable = (dec.acc == ACC_RW) || (dec.acc == ACC_RO);
        writable = (dec.acc == ACC_RW) || (dec.acc == ACC_WO);
        wr_ok    = req_valid && req_wr && !squash && writable;
        wr_bad   = req_wr && !squash && !writable;
        rd_bad   = !req_wr && !readable;
        hit_all  = wr_ok ? dec.inv_all  : '0;
        hit_proc = wr_ok ? dec.inv_proc : '0;
        hit_one  = wr_ok ? dec.inv_one  : '0;
    end

    // Value stored by an accepted write
    always_comb begin
        if (dec.clr)       wr_val = '0;
        else if (dec.set1) wr_val = DATA_W'(1);
        else               wr_val = req_wdata & dec.wmask;
    end

    // Read value with live cycle-count merge
    always_comb begin
        rd_val = regs[sel];
        if (dec.cyc) rd_val = {regs[sel][DATA_W-1:HALF_W], cyc_count[HALF_W-1:0]};
    end

    assign asn_i = regs[IX_ASN_I][ASN_I_LSB +: ASN_W];
    assign asn_d = regs[IX_ASN_D][ASN_D_LSB +: ASN_W];

    // Register storage with reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
            regs[IX_SYSCTL]    <= DATA_W'(6);
            regs[IX_BASE]      <= BASE_CONST;
            regs[SCRATCH_N-1]  <= DATA_W'(cpu_id);
        end else if (wr_ok) begin
            regs[sel] <= wr_val;
        end
    end

    // Response: data and fault one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && (wr_bad || rd_bad);
            rsp_rdata <= (req_valid && !req_wr && readable) ? rd_val : '0;
        end
    end

    // Address and address-space number for single-entry flushes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_addr <= '0;
            flush_asn  <= '0;
        end else if (|hit_one) begin
            flush_addr <= req_wdata;
            flush_asn  <= hit_one[1] ? asn_d : asn_i;
        end
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        priv_ctl_strobe u_strobe (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_all   (hit_all[s]),
            .hit_proc  (hit_proc[s]),
            .hit_one   (hit_one[s]),
            .pulse_all (flush_all[s]),
            .pulse_proc(flush_proc[s]),
            .pulse_one (flush_one[s])
        );
    end

    assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_fault_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_rdata == '0));

    assert_squash_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wr && squash) |=>
            (flush_all == '0 && flush_proc == '0 && flush_one == '0 && !rsp_fault));

    assert_cyc_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wr && req_idx == IDX_W'(IX_CYC)) |=>
            rsp_rdata[HALF_W-1:0] == $past(cyc_count[HALF_W-1:0]));

    assert_single_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_one) |-> flush_addr == $past(req_wdata));

    assert_one_side_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_one));

endmodule

// File: tb/priv_ctl_regs_test.sv
module priv_ctl_regs_test;

    localparam logic [63:0] BASE = 64'h0000_0000_0001_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_wr = 1'b0, squash = 1'b0;
    logic [5:0]  req_idx = '0;
    logic [63:0] req_wdata = '0, cyc_count = '0;
    logic [7:0]  cpu_id = 8'h5C;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_rdata, flush_addr;
    logic [1:0]  flush_all, flush_proc, flush_one;
    logic [6:0]  flush_asn;

    int n_cmp = 0, n_bad = 0;
    logic        done = 1'b0;
    logic        r_valid, r_fault;
    logic [63:0] r_data, r_addr;
    logic [1:0]  r_all, r_proc, r_one;
    logic [6:0]  r_asn;

    always #10 clk = ~clk;

    priv_ctl_regs #(.IDX_W(6), .ID_W(8), .BASE_CONST(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
        .req_idx(req_idx), .req_wdata(req_wdata), .squash(squash),
        .cyc_count(cyc_count), .cpu_id(cpu_id), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .flush_all(flush_all),
        .flush_proc(flush_proc), .flush_one(flush_one),
        .flush_addr(flush_addr), .flush_asn(flush_asn)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [5:0]  idx;
        logic        wr;
        logic [63:0] dat;
        logic [63:0] exp;
        logic        flt;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{4'd3,  6'h03, 1'b1, 64'hA5A5_0000_1234_5678, 64'h0, 1'b0}, // R3
        '{4'd3,  6'h03, 1'b0, 64'h0, 64'hA5A5_0000_1234_5678, 1'b0}, // R3
        '{4'd3,  6'h09, 1'b1, 64'hF1, 64'h0, 1'b0},                  // R3
        '{4'd3,  6'h09, 1'b0, 64'h0, 64'hF1, 1'b0},                  // R3
        '{4'd4,  6'h0A, 1'b1, ONES, 64'h0, 1'b0},                    // R4
        '{4'd4,  6'h0A, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0}, // R4
        '{4'd5,  6'h0C, 1'b1, ONES, 64'h0, 1'b0},                    // R5
        '{4'd5,  6'h0C, 1'b0, 64'h0, 64'hF, 1'b0},                   // R5
        '{4'd5,  6'h0E, 1'b1, 64'hF7, 64'h0, 1'b0},                  // R5
        '{4'd5,  6'h0E, 1'b0, 64'h0, 64'h10, 1'b0},                  // R5
        '{4'd6,  6'h10, 1'b1, ONES, 64'h0, 1'b0},                    // R6
        '{4'd6,  6'h10, 1'b0, 64'h0, 64'h3F, 1'b0},                  // R6
        '{4'd6,  6'h11, 1'b1, ONES, 64'h0, 1'b0},                    // R6
        '{4'd6,  6'h11, 1'b0, 64'h0, 64'h7F0, 1'b0},                 // R6
        '{4'd6,  6'h12, 1'b1, ONES, 64'h0, 1'b0},                    // R6
        '{4'd6,  6'h12, 1'b0, 64'h0, 64'hFE00_0000_0000_0000, 1'b0}, // R6
        '{4'd6,  6'h14, 1'b1, ONES, 64'h0, 1'b0},                    // R6
        '{4'd6,  6'h14, 1'b0, 64'h0, 64'hFFFF_FFFF_C000_0000, 1'b0}, // R6
        '{4'd7,  6'h16, 1'b1, ONES, 64'h0, 1'b0},                    // R7
        '{4'd7,  6'h16, 1'b0, 64'h0, 64'h0, 1'b0},                   // R7
        '{4'd9,  6'h18, 1'b1, 64'h1234, 64'h0, 1'b0},                // R9
        '{4'd9,  6'h18, 1'b0, 64'h0, 64'h1, 1'b0},                   // R9
        '{4'd10, 6'h19, 1'b1, 64'h55, 64'h0, 1'b1},                  // R10
        '{4'd10, 6'h19, 1'b0, 64'h0, 64'h0, 1'b0},                   // R10
        '{4'd10, 6'h1B, 1'b0, 64'h0, 64'h0, 1'b1},                   // R10
        '{4'd10, 6'h2A, 1'b0, 64'h0, 64'h0, 1'b1},                   // R10
        '{4'd10, 6'h2A, 1'b1, ONES, 64'h0, 1'b1}                     // R10
    };

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic xact(input logic [5:0] idx, input logic wr,
                        input logic [63:0] d, input logic sq);
        @(negedge clk);
        req_valid = 1'b1; req_idx = idx; req_wr = wr; req_wdata = d; squash = sq;
        @(negedge clk);
        r_valid = rsp_valid; r_data = rsp_rdata; r_fault = rsp_fault;
        r_all = flush_all; r_proc = flush_proc; r_one = flush_one;
        r_addr = flush_addr; r_asn = flush_asn;
        req_valid = 1'b0; squash = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        xact(6'h09, 1'b0, '0, 1'b0); check("R1", "sysctl", r_data, 64'h6);
        xact(6'h08, 1'b0, '0, 1'b0); check("R1", "base", r_data, BASE);
        xact(6'h07, 1'b0, '0, 1'b0); check("R1", "scratch id", r_data, 64'h5C);
        xact(6'h00, 1'b0, '0, 1'b0); check("R1", "scratch0", r_data, 64'h0);
        xact(6'h17, 1'b0, '0, 1'b0); check("R1", "cyc upper", {32'h0, r_data[63:32]}, 64'h0);

        // R2: response latency and idle
        check("R2", "rsp_valid", {63'h0, r_valid}, 64'h1);
        @(negedge clk);
        check("R2", "idle rsp_valid", {63'h0, rsp_valid}, 64'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            xact(TBL[i].idx, TBL[i].wr, TBL[i].dat, 1'b0);
            check($sformatf("R%0d", TBL[i].rq), $sformatf("idx %h data", TBL[i].idx),
                  r_data, TBL[i].exp);
            check($sformatf("R%0d", TBL[i].rq), $sformatf("idx %h fault", TBL[i].idx),
                  {63'h0, r_fault}, {63'h0, TBL[i].flt});
        end
        // R10: state unchanged after faulting unknown write
        xact(6'h03, 1'b0, '0, 1'b0);
        check("R10", "state after fault", r_data, 64'hA5A5_0000_1234_5678);

        // R8: cycle counter merge
        xact(6'h17, 1'b1, 64'hDEAD_BEEF_1111_1111, 1'b0);
        cyc_count = 64'h0000_0007_CAFE_F00D;
        xact(6'h17, 1'b0, '0, 1'b0);
        check("R8", "cyc merge", r_data, 64'hDEAD_BEEF_CAFE_F00D);
        cyc_count = 64'h0000_0000_0000_0042;
        xact(6'h17, 1'b0, '0, 1'b0);
        check("R8", "cyc live", r_data, 64'hDEAD_BEEF_0000_0042);

        // R11: invalidate-all / per-process strobes
        xact(6'h1A, 1'b1, ONES, 1'b0);
        check("R11", "all I", {62'h0, r_all}, 64'h1);
        check("R11", "proc none", {62'h0, r_proc}, 64'h0);
        @(negedge clk);
        check("R11", "all I width", {62'h0, flush_all}, 64'h0);
        xact(6'h1D, 1'b1, ONES, 1'b0);
        check("R11", "all D", {62'h0, r_all}, 64'h2);
        xact(6'h1B, 1'b1, ONES, 1'b0);
        check("R11", "proc I", {62'h0, r_proc}, 64'h1);
        xact(6'h1E, 1'b1, ONES, 1'b0);
        check("R11", "proc D", {62'h0, r_proc}, 64'h2);

        // R12: invalidate-single with address-space numbers
        xact(6'h11, 1'b1, 64'h350, 1'b0);
        xact(6'h12, 1'b1, 64'h0600_0000_0000_0000, 1'b0);
        xact(6'h1C, 1'b1, 64'h0000_1234_0000_4000, 1'b0);
        check("R12", "one I", {62'h0, r_one}, 64'h1);
        check("R12", "addr I", r_addr, 64'h0000_1234_0000_4000);
        check("R12", "asn I", {57'h0, r_asn}, 64'h35);
        xact(6'h1F, 1'b1, 64'h0000_0000_8000_2000, 1'b0);
        check("R12", "one D", {62'h0, r_one}, 64'h2);
        check("R12", "addr D", r_addr, 64'h0000_0000_8000_2000);
        check("R12", "asn D", {57'h0, r_asn}, 64'h03);

        // R13: squash
        xact(6'h03, 1'b1, 64'h1111, 1'b1);
        check("R13", "squash no fault", {63'h0, r_fault}, 64'h0);
        xact(6'h03, 1'b0, '0, 1'b1);
        check("R13", "read under squash", r_data, 64'hA5A5_0000_1234_5678);
        xact(6'h1A, 1'b1, ONES, 1'b1);
        check("R13", "squash no flush", {62'h0, r_all}, 64'h0);
        xact(6'h1F, 1'b1, ONES, 1'b1);
        check("R13", "squash no single", {62'h0, r_one}, 64'h0);
        xact(6'h19, 1'b1, ONES, 1'b1);
        check("R13", "squash RO no fault", {63'h0, r_fault}, 64'h0);
        xact(6'h16, 1'b1, ONES, 1'b1);
        xact(6'h18, 1'b0, '0, 1'b0);
        check("R13", "cycctl kept", r_data, 64'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule